// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This block is the control core of a power-management controller that brings a processor subsystem out of an unpowered state. It raises the supply rails in a fixed order: the I/O rail first, then the PLL and core rails together, then the processor rail. It then starts the slow (32 kHz) clock and, after a fixed oscillator start-up window, the high-frequency clock. Only after that does it release the active-low power-on reset. Each rail is modelled as an enable output answered by a power-good input. Every wait on a power-good has a timeout, and a timeout aborts into the shutdown sequence with a sticky fault flag.

Two boot-mode pins select who may start the machine. In master mode a push button starts it, after a debounce filter. In slave mode a digital request from another controller starts it. Shutdown runs in reverse: the reset is asserted and the fast clock stopped first, and the rails and slow clock drop one cycle later. While the subsystem is running, a warm-reset request pulses the reset low for a programmable number of cycles and leaves rails and clocks alone. All counts are in cycles of `clk`, which is the slow-clock domain.

Top module: `rail_sequencer`

## Requirements
- R1: Boot mode decodes as `bootMode[0]=1, bootMode[1]=0` for master and `bootMode=2'b11` for slave. Any other value never starts a power-up.
- R2: In master mode, the button passes through a two-stage synchronizer and is accepted only after DEB_LEN (default 64) consecutive identical synchronized samples. A shorter pulse has no effect. The accepted press appears on ioEn DEB_LEN+3 cycles after the button rises. An accepted press while powered starts the shutdown.
- R3: In slave mode, a rising edge on slaveOn starts a power-up. slaveOn low in any powered state starts the shutdown.
- R4: ioEn rises first, with porN low. pllEn and coreEn rise together in the cycle after ioGood is seen.
- R5: cpuEn rises only after both pllGood and coreGood are seen.
- R6: slowClkEn rises in the cycle after cpuGood is seen. fastClkEn rises exactly HF_DELAY cycles after slowClkEn.
- R7: porN rises exactly SETTLE_LEN cycles after fastClkEn, and porN is high only while every rail and both clocks are enabled.
- R8: If a rail wait lasts RAIL_TIMEOUT cycles without its power-good, fault is set and the shutdown starts. fault stays set until the next power-up starts.
- R9: Shutdown first drives porN low and fastClkEn low with the rails still on. One cycle later all rails and slowClkEn go low.
- R10: A rising edge on warmReq while running drives porN low for max(warmCycles,1) cycles. Rails and clocks do not change.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-clock domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootMode | input | 2 | Boot pins: 01 master, 11 slave |
| buttonIn | input | 1 | Raw push button, high when pressed |
| slaveOn | input | 1 | Power-on request from another controller |
| warmReq | input | 1 | Warm-reset request, rising-edge sensitive |
| warmCycles | input | WARM_W | Warm-reset pulse length in cycles (0 acts as 1) |
| ioGood | input | 1 | I/O rail power-good |
| pllGood | input | 1 | PLL rail power-good |
| coreGood | input | 1 | Core rail power-good |
| cpuGood | input | 1 | Processor rail power-good |
| ioEn | output | 1 | I/O rail enable |
| pllEn | output | 1 | PLL rail enable |
| coreEn | output | 1 | Core rail enable |
| cpuEn | output | 1 | Processor rail enable |
| slowClkEn | output | 1 | 32 kHz clock output enable |
| fastClkEn | output | 1 | High-frequency clock output enable |
| porN | output | 1 | Active-low power-on reset |
| fault | output | 1 | Sticky rail-timeout flag |

## Verification
Every output is a register that changes on the edge where the control state moves. A power-good, slaveOn edge or warmReq edge seen at one edge therefore shows on the outputs right after that edge. A button press takes the two synchronizer stages, the DEB_LEN-sample filter and the press register before it shows on ioEn, which is DEB_LEN+3 cycles. The bench holds a behavioural model that advances on each rising edge from the same input values. It compares all eight outputs at the following falling edge, so each result is read in the cycle it becomes due. The scenario checks count falling edges from the stimulus and compare the count with DEB_LEN+3, HF_DELAY, SETTLE_LEN, RAIL_TIMEOUT and the warm pulse length.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_IO,
    ST_PC,
    ST_CPU,
    ST_SLOW,
    ST_FAST,
    ST_RUN,
    ST_WARM,
    ST_PD
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic tmrClr;
    logic ioOn;
    logic pcOn;
    logic cpuOn;
    logic slowOn;
    logic fastOn;
    logic porRelease;
    logic porAssert;
    logic fastOff;
    logic allOff;
    logic faultSet;
    logic faultClr;
  } seqCmd_t;

endpackage

// File: rtl/rail_seq_debounce.sv
module rail_seq_debounce #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic pressPulse
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEN - 1);

  logic syncA, syncB, stableLvl;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      stableLvl  <= 1'b0;
      runCnt     <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncA      <= rawIn;
      syncB      <= syncA;
      pressPulse <= 1'b0;
      if (syncB != stableLvl) begin
        if (runCnt == CNT_LAST) begin
          stableLvl  <= syncB;
          runCnt     <= '0;
          pressPulse <= syncB;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R2: a press pulse only follows a settled high level
  a_r2_press_after_settle: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |-> stableLvl);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] bootMode,
  input  logic       pressPulse,
  input  logic       slaveOn,
  input  logic       slaveRise,
  input  logic       warmRise,
  input  logic       ioGood,
  input  logic       pllGood,
  input  logic       coreGood,
  input  logic       cpuGood,
  input  logic       railTimeout,
  input  logic       hfDone,
  input  logic       settleDone,
  input  logic       warmDone,
  output seqCmd_t    cmd
);
  seqState_t st, stNext;
  logic isMaster, isSlave, startReq, stopReq;

  assign isMaster = (bootMode == 2'b01);
  assign isSlave  = (bootMode == 2'b11);
  assign startReq = (isMaster && pressPulse) || (isSlave && slaveRise);
  assign stopReq  = (isMaster && pressPulse) || (isSlave && !slaveOn);

  always_comb begin
    stNext = st;
    cmd    = '0;
    unique case (st)
      ST_OFF: begin
        if (startReq) begin
          stNext       = ST_IO;
          cmd.ioOn     = 1'b1;
          cmd.tmrClr   = 1'b1;
          cmd.faultClr = 1'b1;
        end
      end
      ST_IO, ST_PC, ST_CPU: begin
        if (stopReq) begin
          stNext = ST_PD;
        end else if (st == ST_IO && ioGood) begin
          stNext     = ST_PC;
          cmd.pcOn   = 1'b1;
          cmd.tmrClr = 1'b1;
        end else if (st == ST_PC && pllGood && coreGood) begin
          stNext     = ST_CPU;
          cmd.cpuOn  = 1'b1;
          cmd.tmrClr = 1'b1;
        end else if (st == ST_CPU && cpuGood) begin
          stNext     = ST_SLOW;
          cmd.slowOn = 1'b1;
          cmd.tmrClr = 1'b1;
        end else if (railTimeout) begin
          stNext       = ST_PD;
          cmd.faultSet = 1'b1;
        end
      end
      ST_SLOW: begin
        if (stopReq) begin
          stNext = ST_PD;
        end else if (hfDone) begin
          stNext     = ST_FAST;
          cmd.fastOn = 1'b1;
          cmd.tmrClr = 1'b1;
        end
      end
      ST_FAST: begin
        if (stopReq) begin
          stNext = ST_PD;
        end else if (settleDone) begin
          stNext         = ST_RUN;
          cmd.porRelease = 1'b1;
        end
      end
      ST_RUN: begin
        if (stopReq) begin
          stNext = ST_PD;
        end else if (warmRise) begin
          stNext        = ST_WARM;
          cmd.porAssert = 1'b1;
          cmd.tmrClr    = 1'b1;
        end
      end
      ST_WARM: begin
        if (stopReq) begin
          stNext = ST_PD;
        end else if (warmDone) begin
          stNext         = ST_RUN;
          cmd.porRelease = 1'b1;
        end
      end
      ST_PD: begin
        stNext     = ST_OFF;
        cmd.allOff = 1'b1;
      end
      default: stNext = ST_OFF;
    endcase
    // entry into shutdown: reset low and fast clock off first
    if (st != ST_PD && stNext == ST_PD) begin
      cmd.porAssert = 1'b1;
      cmd.fastOff   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_OFF;
    else       st <= stNext;
  end

  // R1: with an undefined boot mode the machine never leaves OFF
  a_r1_no_start_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OFF && !isMaster && !isSlave) |=> (st == ST_OFF));

  // R9: shutdown always lasts one cycle before OFF
  a_r9_pd_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PD) |=> (st == ST_OFF));

endmodule

// File: rtl/rail_seq_dp.sv
module rail_seq_dp
  import rail_seq_pkg::*;
#(
  parameter int RAIL_TIMEOUT = 200,
  parameter int HF_DELAY     = 173,
  parameter int SETTLE_LEN   = 4,
  parameter int WARM_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic              slaveOn,
  input  logic              warmReq,
  input  logic [WARM_W-1:0] warmCycles,
  output logic              slaveRise,
  output logic              warmRise,
  output logic              railTimeout,
  output logic              hfDone,
  output logic              settleDone,
  output logic              warmDone,
  output logic              ioEn,
  output logic              pllEn,
  output logic              coreEn,
  output logic              cpuEn,
  output logic              slowClkEn,
  output logic              fastClkEn,
  output logic              porN,
  output logic              fault
);
  localparam int MAX_A  = (RAIL_TIMEOUT > HF_DELAY) ? RAIL_TIMEOUT : HF_DELAY;
  localparam int MAX_B  = (MAX_A > SETTLE_LEN) ? MAX_A : SETTLE_LEN;
  localparam int MAX_C  = (MAX_B > (1 << WARM_W)) ? MAX_B : (1 << WARM_W);
  localparam int TMR_W  = $clog2(MAX_C) + 1;

  logic [TMR_W-1:0]  tmr;
  logic [WARM_W-1:0] warmLast;
  logic slavePrev, warmPrev;

  assign slaveRise = slaveOn && !slavePrev;
  assign warmRise  = warmReq && !warmPrev;
  assign warmLast  = (warmCycles == '0) ? '0 : warmCycles - 1'b1;

  assign railTimeout = (tmr == TMR_W'(RAIL_TIMEOUT - 1));
  assign hfDone      = (tmr == TMR_W'(HF_DELAY - 1));
  assign settleDone  = (tmr == TMR_W'(SETTLE_LEN - 1));
  assign warmDone    = (tmr == TMR_W'(warmLast));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr       <= '0;
      slavePrev <= 1'b0;
      warmPrev  <= 1'b0;
    end else begin
      slavePrev <= slaveOn;
      warmPrev  <= warmReq;
      if (cmd.tmrClr)    tmr <= '0;
      else if (tmr != '1) tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioEn      <= 1'b0;
      pllEn     <= 1'b0;
      coreEn    <= 1'b0;
      cpuEn     <= 1'b0;
      slowClkEn <= 1'b0;
      fastClkEn <= 1'b0;
      porN      <= 1'b0;
      fault     <= 1'b0;
    end else begin
      if (cmd.allOff) begin
        ioEn      <= 1'b0;
        pllEn     <= 1'b0;
        coreEn    <= 1'b0;
        cpuEn     <= 1'b0;
        slowClkEn <= 1'b0;
      end else begin
        if (cmd.ioOn)   ioEn      <= 1'b1;
        if (cmd.pcOn) begin
          pllEn  <= 1'b1;
          coreEn <= 1'b1;
        end
        if (cmd.cpuOn)  cpuEn     <= 1'b1;
        if (cmd.slowOn) slowClkEn <= 1'b1;
      end
      if (cmd.fastOff || cmd.allOff) fastClkEn <= 1'b0;
      else if (cmd.fastOn)           fastClkEn <= 1'b1;
      if (cmd.porAssert || cmd.allOff) porN <= 1'b0;
      else if (cmd.porRelease)         porN <= 1'b1;
      if (cmd.faultSet)      fault <= 1'b1;
      else if (cmd.faultClr) fault <= 1'b0;
    end
  end

  a_r4_pc_after_io: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> ($past(ioEn) && coreEn));

  a_r5_cpu_after_core: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuEn) |-> $past(pllEn && coreEn));

  a_r6_fast_needs_slow: assert property (@(posedge clk) disable iff (!rstN)
    fastClkEn |-> (slowClkEn && cpuEn));

  a_r7_por_needs_all: assert property (@(posedge clk) disable iff (!rstN)
    porN |-> (ioEn && pllEn && coreEn && cpuEn && slowClkEn && fastClkEn));

  a_r8_fault_then_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |=> !ioEn);

  a_r9_reset_before_rails: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ioEn) |-> $past(!porN && !fastClkEn));

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int DEB_LEN      = 64,
  parameter int RAIL_TIMEOUT = 200,
  parameter int HF_DELAY     = 173,
  parameter int SETTLE_LEN   = 4,
  parameter int WARM_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bootMode,
  input  logic              buttonIn,
  input  logic              slaveOn,
  input  logic              warmReq,
  input  logic [WARM_W-1:0] warmCycles,
  input  logic              ioGood,
  input  logic              pllGood,
  input  logic              coreGood,
  input  logic              cpuGood,
  output logic              ioEn,
  output logic              pllEn,
  output logic              coreEn,
  output logic              cpuEn,
  output logic              slowClkEn,
  output logic              fastClkEn,
  output logic              porN,
  output logic              fault
);
  seqCmd_t cmd;
  logic pressPulse, slaveRise, warmRise;
  logic railTimeout, hfDone, settleDone, warmDone;

  rail_seq_debounce #(.LEN(DEB_LEN)) u_debounce (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (buttonIn),
    .pressPulse (pressPulse)
  );

  rail_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bootMode    (bootMode),
    .pressPulse  (pressPulse),
    .slaveOn     (slaveOn),
    .slaveRise   (slaveRise),
    .warmRise    (warmRise),
    .ioGood      (ioGood),
    .pllGood     (pllGood),
    .coreGood    (coreGood),
    .cpuGood     (cpuGood),
    .railTimeout (railTimeout),
    .hfDone      (hfDone),
    .settleDone  (settleDone),
    .warmDone    (warmDone),
    .cmd         (cmd)
  );

  rail_seq_dp #(
    .RAIL_TIMEOUT (RAIL_TIMEOUT),
    .HF_DELAY     (HF_DELAY),
    .SETTLE_LEN   (SETTLE_LEN),
    .WARM_W       (WARM_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .slaveOn     (slaveOn),
    .warmReq     (warmReq),
    .warmCycles  (warmCycles),
    .slaveRise   (slaveRise),
    .warmRise    (warmRise),
    .railTimeout (railTimeout),
    .hfDone      (hfDone),
    .settleDone  (settleDone),
    .warmDone    (warmDone),
    .ioEn        (ioEn),
    .pllEn       (pllEn),
    .coreEn      (coreEn),
    .cpuEn       (cpuEn),
    .slowClkEn   (slowClkEn),
    .fastClkEn   (fastClkEn),
    .porN        (porN),
    .fault       (fault)
  );

endmodule

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;
  localparam int DEB = 64;
  localparam int RT  = 200;
  localparam int HF  = 173;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] bootMode = 2'b00;
  logic buttonIn = 1'b0, slaveOn = 1'b0, warmReq = 1'b0;
  logic [7:0] warmCycles = 8'd5;
  logic ioGood = 1'b0, pllGood = 1'b0, coreGood = 1'b0, cpuGood = 1'b0;
  logic ioEn, pllEn, coreEn, cpuEn, slowClkEn, fastClkEn, porN, fault;

  int checks = 0;
  int failures = 0;
  bit blockCore = 1'b0;

  always #5 clk = ~clk;

  rail_sequencer #(.DEB_LEN(DEB), .RAIL_TIMEOUT(RT), .HF_DELAY(HF),
                   .SETTLE_LEN(SET), .WARM_W(8)) u_rail_sequencer (
    .clk(clk), .rstN(rstN), .bootMode(bootMode), .buttonIn(buttonIn),
    .slaveOn(slaveOn), .warmReq(warmReq), .warmCycles(warmCycles),
    .ioGood(ioGood), .pllGood(pllGood), .coreGood(coreGood), .cpuGood(cpuGood),
    .ioEn(ioEn), .pllEn(pllEn), .coreEn(coreEn), .cpuEn(cpuEn),
    .slowClkEn(slowClkEn), .fastClkEn(fastClkEn), .porN(porN), .fault(fault));

  // rail behaviour: power-good follows enable after a fixed ramp time
  int ioCnt = 0, pllCnt = 0, coreCnt = 0, cpuCnt = 0;
  always @(negedge clk) begin
    ioCnt   = ioEn   ? ioCnt + 1   : 0;
    pllCnt  = pllEn  ? pllCnt + 1  : 0;
    coreCnt = coreEn ? coreCnt + 1 : 0;
    cpuCnt  = cpuEn  ? cpuCnt + 1  : 0;
    ioGood   = (ioCnt >= 5);
    pllGood  = (pllCnt >= 3);
    coreGood = (coreCnt >= 7) && !blockCore;
    cpuGood  = (cpuCnt >= 4);
  end

  // behavioural reference model, advanced on each rising edge
  int mPh = 0, mTmr = 0, mRun = 0;
  logic mS1 = 0, mS2 = 0, mStable = 0, mPress = 0, mSlvPrev = 0, mWarmPrev = 0;
  logic eIo = 0, ePll = 0, eCore = 0, eCpu = 0, eSlow = 0, eFast = 0, ePor = 0, eFault = 0;

  always @(posedge clk) begin : refModel
    logic oldS2, press, sRise, wRise, master, slave, start, stop, newPress, goPd;
    int t, wl;
    if (!rstN) begin
      mPh = 0; mTmr = 0; mRun = 0;
      mS1 = 0; mS2 = 0; mStable = 0; mPress = 0; mSlvPrev = 0; mWarmPrev = 0;
      {eIo, ePll, eCore, eCpu, eSlow, eFast, ePor, eFault} = '0;
    end else begin
      press = mPress;
      sRise = slaveOn && !mSlvPrev;
      wRise = warmReq && !mWarmPrev;
      mSlvPrev = slaveOn; mWarmPrev = warmReq;
      oldS2 = mS2; mS2 = mS1; mS1 = buttonIn;
      newPress = 0;
      if (oldS2 != mStable) begin
        if (mRun == DEB - 1) begin mStable = oldS2; mRun = 0; newPress = oldS2; end
        else mRun++;
      end else mRun = 0;
      mPress = newPress;
      master = (bootMode == 2'b01);
      slave  = (bootMode == 2'b11);
      start  = (master && press) || (slave && sRise);
      stop   = (master && press) || (slave && !slaveOn);
      t = mTmr; mTmr = mTmr + 1;
      wl = (warmCycles == 0) ? 0 : int'(warmCycles) - 1;
      goPd = 0;
      case (mPh)
        0: if (start) begin mPh = 1; eIo = 1; eFault = 0; mTmr = 0; end
        1: if (stop) goPd = 1;
           else if (ioGood) begin mPh = 2; ePll = 1; eCore = 1; mTmr = 0; end
           else if (t == RT - 1) begin goPd = 1; eFault = 1; end
        2: if (stop) goPd = 1;
           else if (pllGood && coreGood) begin mPh = 3; eCpu = 1; mTmr = 0; end
           else if (t == RT - 1) begin goPd = 1; eFault = 1; end
        3: if (stop) goPd = 1;
           else if (cpuGood) begin mPh = 4; eSlow = 1; mTmr = 0; end
           else if (t == RT - 1) begin goPd = 1; eFault = 1; end
        4: if (stop) goPd = 1;
           else if (t == HF - 1) begin mPh = 5; eFast = 1; mTmr = 0; end
        5: if (stop) goPd = 1;
           else if (t == SET - 1) begin mPh = 6; ePor = 1; end
        6: if (stop) goPd = 1;
           else if (wRise) begin mPh = 7; ePor = 0; mTmr = 0; end
        7: if (stop) goPd = 1;
           else if (t == wl) begin mPh = 6; ePor = 1; end
        default: begin mPh = 0; {eIo, ePll, eCore, eCpu, eSlow, eFast, ePor} = '0; end
      endcase
      if (goPd) begin mPh = 8; ePor = 0; eFast = 0; end
    end
  end

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    checks++;
    if ({ioEn, pllEn, coreEn} !== {eIo, ePll, eCore}) begin
      failures++;
      $display("FAIL R4 rails io/pll/core act=%b%b%b exp=%b%b%b at %0t", ioEn, pllEn, coreEn, eIo, ePll, eCore, $time);
    end
    if (cpuEn !== eCpu) begin
      failures++; $display("FAIL R5 cpuEn act=%b exp=%b at %0t", cpuEn, eCpu, $time);
    end
    if ({slowClkEn, fastClkEn} !== {eSlow, eFast}) begin
      failures++; $display("FAIL R6 clocks act=%b%b exp=%b%b at %0t", slowClkEn, fastClkEn, eSlow, eFast, $time);
    end
    if (porN !== ePor) begin
      failures++; $display("FAIL R7 porN act=%b exp=%b at %0t", porN, ePor, $time);
    end
    if (fault !== eFault) begin
      failures++; $display("FAIL R8 fault act=%b exp=%b at %0t", fault, eFault, $time);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    tick(3);
    chk("R11 outputs in reset", {ioEn, pllEn, coreEn, cpuEn, slowClkEn, fastClkEn, porN, fault}, 0);
    rstN = 1'b1;
    tick(2);

    // R1: undefined boot modes never start
    bootMode = 2'b00; buttonIn = 1'b1; tick(100);
    chk("R1 mode 00 ignores button", ioEn, 0);
    buttonIn = 1'b0; tick(80);
    bootMode = 2'b10; slaveOn = 1'b1; tick(5);
    chk("R1 mode 10 ignores slaveOn", ioEn, 0);
    slaveOn = 1'b0; tick(5);

    // R2: short glitch rejected, long press accepted
    bootMode = 2'b01;
    buttonIn = 1'b1; tick(30); buttonIn = 1'b0; tick(100);
    chk("R2 glitch ignored", ioEn, 0);
    buttonIn = 1'b1;
    n = 0;
    do begin tick(1); n++; end while (!ioEn && n < 500);
    chk("R2 press latency", n, DEB + 3);
    chk("R4 pll off while io ramps", pllEn, 0);
    chk("R4 reset low during ramp", porN, 0);
    n = 0;
    while (!pllEn && n < 500) begin tick(1); n++; end
    chk("R4 pll and core together", {pllEn, coreEn}, 3);
    n = 0;
    while (!slowClkEn && n < 500) begin tick(1); n++; end
    chk("R5 cpu on before clocks", cpuEn, 1);
    n = 0;
    while (!fastClkEn && n < 1000) begin tick(1); n++; end
    chk("R6 fast clock delay", n, HF);
    n = 0;
    while (!porN && n < 100) begin tick(1); n++; end
    chk("R7 reset release delay", n, SET);
    chk("R7 all enabled at release", {ioEn, pllEn, coreEn, cpuEn, slowClkEn, fastClkEn}, 6'h3f);
    buttonIn = 1'b0; tick(100);
    chk("R2 button release keeps running", porN, 1);

    // R10: warm reset pulses
    warmCycles = 8'd5; warmReq = 1'b1; tick(1); warmReq = 1'b0;
    chk("R10 rails kept in warm reset", {ioEn, cpuEn, fastClkEn}, 7);
    n = 0;
    while (!porN && n < 100) begin n++; tick(1); end
    chk("R10 warm pulse length 5", n, 5);
    tick(3);
    warmCycles = 8'd0; warmReq = 1'b1; tick(1); warmReq = 1'b0;
    n = 0;
    while (!porN && n < 100) begin n++; tick(1); end
    chk("R10 warm pulse length for zero", n, 1);
    tick(3);

    // R9: master press while running shuts down
    buttonIn = 1'b1;
    n = 0;
    while (porN && n < 500) begin tick(1); n++; end
    chk("R9 first step reset and fast off, rails on", {porN, fastClkEn, ioEn, slowClkEn}, 3);
    tick(1);
    chk("R9 second step rails off", {ioEn, pllEn, coreEn, cpuEn, slowClkEn}, 0);
    buttonIn = 1'b0; tick(100);

    // R3: slave start and stop
    bootMode = 2'b11; slaveOn = 1'b1;
    n = 0;
    while (!porN && n < 1000) begin tick(1); n++; end
    chk("R3 slave power-up completes", porN, 1);
    slaveOn = 1'b0; tick(2);
    chk("R3 slave low shuts down", {ioEn, porN}, 0);
    tick(3);

    // R8: timeout on the core rail
    blockCore = 1'b1; slaveOn = 1'b1;
    n = 0;
    while (!pllEn && n < 100) begin tick(1); n++; end
    n = 0;
    while (!fault && n < 1000) begin tick(1); n++; end
    chk("R8 timeout length", n, RT);
    chk("R8 cpu rail never enabled", cpuEn, 0);
    tick(1);
    chk("R8 rails off after timeout", {ioEn, pllEn, coreEn}, 0);
    chk("R8 fault sticky", fault, 1);
    blockCore = 1'b0; slaveOn = 1'b0; tick(3);
    slaveOn = 1'b1; tick(2);
    chk("R8 fault cleared by restart", fault, 0);
    n = 0;
    while (!porN && n < 1000) begin tick(1); n++; end
    chk("R7 restart reaches run", porN, 1);
    slaveOn = 1'b0; tick(5);

    finishRun();
  end
endmodule